// File: doc/BRIEF.md
# Windowed Watchdog Timer

The block is a supervisory timer built around an up counter that advances once on every cycle in which a source-clock tick enable is high. Software must service it by writing a clear code. If the counter wraps from its maximum value back to zero before a valid clear, the block raises a one-cycle request. A control bit selects whether that request is a reset request or an interrupt request. The watchdog starts running out of reset without any software action.

Clears can be restricted to a window near the end of the count period. A clear attempted too early leaves the counter running and raises an interrupt request, so code stuck in a tight servicing loop is caught as well. Stopping the watchdog needs two separate steps: software first writes the control enable bit to 0 and then writes a dedicated stop code. Setting the enable bit back to 1 restarts it, and no code write is needed for that. Software can read the live count at any time to confirm that it is advancing.

The register interface is a single write port. `wr_sel_i` = 0 selects the control register and `wr_sel_i` = 1 selects the code register. The control register fields are: bit 0 is enable, bits 2:1 are the window select, and bit 3 is the overflow action (1 gives a reset request, 0 gives an interrupt request).

Top module: `windowed_watchdog`

## Requirements
- R1: After reset the count reads 0, both requests are low, and the control register holds enable=1, window=00, action=1. The count then rises by exactly one for each cycle with `tick_i` high and holds in every other cycle.
- R2: When the count wraps from 0xFF to 0x00 while running, one request pulse lasting a single cycle appears in the cycle after the wrapping tick. It is `rst_req_o` if control bit 3 is 1 and `irq_req_o` if control bit 3 is 0.
- R3: Writing 0 to the enable bit (control bit 0) on its own does not stop the counter.
- R4: A write of 0xB1 to the code register while the enable bit is 0 stops the watchdog. The count is forced to 0 and stays at 0 regardless of ticks, and no request is raised.
- R5: While stopped, a control write with bit 0 set restarts counting from 0, and no code write is needed.
- R6: With window select 00, a write of the clear code 0x4E sets the count to 0 whatever its value, and no request is raised.
- R7: Window select 01, 10 and 11 accept a clear only when the count is at least 0x80, 0xC0 and 0xE0 respectively. An accepted clear sets the count to 0 without a request.
- R8: A clear code written while the count is below the selected threshold leaves the count unchanged and pulses `irq_req_o` in the next cycle.
- R9: A 0xB1 write in the same cycle as a wrapping tick suppresses the overflow request. With the enable bit at 0 the watchdog also stops. With the enable bit at 1 it keeps counting from 0.
- R10: Code values other than 0x4E and 0xB1 have no effect on the count or the requests. A clear code written while the watchdog is stopped is also ignored.
- R11: `count_o` always shows the current counter value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Source-clock tick enable, one count step per high cycle |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 1 | Write target: 0 control register, 1 code register |
| wr_data_i | input | 8 | Write data |
| count_o | output | 8 | Current counter value |
| rst_req_o | output | 1 | One-cycle reset request on overflow |
| irq_req_o | output | 1 | One-cycle interrupt request on overflow or early clear |

## Verification
Every result is registered, so a tick, clear, stop or restart presented before clock edge N shows on `count_o` just after edge N. The request pulse caused by a stimulus at edge N is visible only between edge N and edge N+1. The bench drives each stimulus for exactly one edge and samples 1 ns after that edge. It therefore checks the count and each pulse in the one cycle where the result belongs, and checks again one cycle later that the pulse has gone. During long tick runs every sampled cycle is watched for stray requests.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // Control register fields: bit 0 enable, bits 2:1 window, bit 3 action
   typedef struct packed {
      logic       act_rst;
      logic [1:0] win;
      logic       en;
   } wdt_ctrl_t;

   localparam int unsigned CTRL_W = 4;
   localparam wdt_ctrl_t   CTRL_RESET = '{act_rst: 1'b1, win: 2'b00, en: 1'b1};

endpackage

// File: rtl/wdt_regs.sv
module wdt_regs
   import wdt_pkg::*;
#(
   parameter int unsigned       DATA_W   = 8,
   parameter logic [DATA_W-1:0] CLR_CODE = 8'h4E,
   parameter logic [DATA_W-1:0] DIS_CODE = 8'hB1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en_i,
   input  logic              wr_sel_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output wdt_ctrl_t         ctrl_o,
   output logic              run_o,
   output logic              stop_o,
   output logic              dis_wr_o,
   output logic              clr_wr_o
);

   logic      ctrl_wr, code_wr;
   wdt_ctrl_t ctrl_q;
   logic      run_q;

   assign ctrl_wr  = wr_en_i && !wr_sel_i;
   assign code_wr  = wr_en_i &&  wr_sel_i;
   assign dis_wr_o = code_wr && (wr_data_i == DIS_CODE);
   assign clr_wr_o = code_wr && (wr_data_i == CLR_CODE);
   // stopping needs the enable bit already cleared by an earlier write
   assign stop_o   = dis_wr_o && !ctrl_q.en;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= CTRL_RESET;
      end else if (ctrl_wr) begin
         ctrl_q <= wdt_ctrl_t'(wr_data_i[CTRL_W-1:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q <= 1'b1;
      end else if (stop_o) begin
         run_q <= 1'b0;
      end else if (ctrl_wr && wr_data_i[0]) begin
         run_q <= 1'b1;
      end
   end

   assign ctrl_o = ctrl_q;
   assign run_o  = run_q;

   // R3
   keep_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !stop_o) |=> run_q);

endmodule

// File: rtl/wdt_window.sv
module wdt_window #(
   parameter int unsigned CNT_W = 8
) (
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [1:0]       win_i,
   output logic             in_win_o
);

   logic [3:0] hit;

   assign hit[0] = 1'b1;

   // threshold for select w is the top 1/2^w of the period
   for (genvar w = 1; w < 4; w++) begin : g_thr
      localparam int unsigned        THR   = (1 << CNT_W) - (1 << (CNT_W - w));
      localparam logic [CNT_W-1:0]   THR_V = THR[CNT_W-1:0];
      assign hit[w] = (cnt_i >= THR_V);
   end

   assign in_win_o = hit[win_i];

endmodule

// File: rtl/wdt_counter.sv
module wdt_counter #(
   parameter int unsigned CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_i,
   input  logic             stop_i,
   input  logic             clr_i,
   input  logic             tick_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             wrap_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   logic [CNT_W-1:0] cnt_q;
   logic             step;

   assign step   = run_i && !stop_i && !clr_i && tick_i;
   assign wrap_o = step && (cnt_q == CNT_MAX);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (!run_i || stop_i || clr_i) begin
         cnt_q <= '0;
      end else if (tick_i) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign cnt_o = cnt_q;

   // R4
   stopped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |-> (cnt_q == '0));

   // R1
   tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !stop_i && !clr_i && tick_i) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/windowed_watchdog.sv
module windowed_watchdog
   import wdt_pkg::*;
#(
   parameter int unsigned       CNT_W    = 8,
   parameter int unsigned       DATA_W   = 8,
   parameter logic [DATA_W-1:0] CLR_CODE = 8'h4E,
   parameter logic [DATA_W-1:0] DIS_CODE = 8'hB1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              wr_en_i,
   input  logic              wr_sel_i,
   input  logic [DATA_W-1:0] wr_data_i,
   output logic [CNT_W-1:0]  count_o,
   output logic              rst_req_o,
   output logic              irq_req_o
);

   if (CNT_W < 3 || CNT_W > 16) begin : g_bad_cnt
      $error("windowed_watchdog: CNT_W must be 3..16");
   end
   if (DATA_W < CTRL_W) begin : g_bad_data
      $error("windowed_watchdog: DATA_W too narrow for control fields");
   end
   if (CLR_CODE == DIS_CODE) begin : g_bad_code
      $error("windowed_watchdog: clear and stop codes must differ");
   end

   wdt_ctrl_t        ctrl;
   logic             run, stop, dis_wr, clr_wr;
   logic             in_win, clr_ok, early_clr, wrap, ovf;
   logic [CNT_W-1:0] cnt;
   logic             rst_q, irq_q;

   wdt_regs #(
      .DATA_W   (DATA_W),
      .CLR_CODE (CLR_CODE),
      .DIS_CODE (DIS_CODE)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en_i   (wr_en_i),
      .wr_sel_i  (wr_sel_i),
      .wr_data_i (wr_data_i),
      .ctrl_o    (ctrl),
      .run_o     (run),
      .stop_o    (stop),
      .dis_wr_o  (dis_wr),
      .clr_wr_o  (clr_wr)
   );

   wdt_window #(.CNT_W(CNT_W)) u_win (
      .cnt_i    (cnt),
      .win_i    (ctrl.win),
      .in_win_o (in_win)
   );

   assign clr_ok    = run && clr_wr &&  in_win;
   assign early_clr = run && clr_wr && !in_win;

   wdt_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk    (clk),
      .rst_n  (rst_n),
      .run_i  (run),
      .stop_i (stop),
      .clr_i  (clr_ok),
      .tick_i (tick_i),
      .cnt_o  (cnt),
      .wrap_o (wrap)
   );

   // a stop-code write masks a same-cycle overflow
   assign ovf = wrap && !dis_wr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         rst_q <= ovf &&  ctrl.act_rst;
         irq_q <= (ovf && !ctrl.act_rst) || early_clr;
      end
   end

   assign count_o   = cnt;
   assign rst_req_o = rst_q;
   assign irq_req_o = irq_q;

   // R2
   rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_q |=> !rst_q);

   // R2
   one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(rst_q && irq_q));

   // R8
   early_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      early_clr |=> (irq_q && $stable(cnt)));

endmodule

// File: tb/tb_windowed_watchdog.sv
module tb_windowed_watchdog;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       tick, wr_en, wr_sel;
   logic [7:0] wr_data;
   logic [7:0] count;
   logic       rst_req, irq_req;

   int errors = 0;
   int checks = 0;
   bit seen;

   always #5 clk = ~clk;

   windowed_watchdog dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick),
      .wr_en_i   (wr_en),
      .wr_sel_i  (wr_sel),
      .wr_data_i (wr_data),
      .count_o   (count),
      .rst_req_o (rst_req),
      .irq_req_o (irq_req)
   );

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic cyc(bit t, bit we, bit sel, logic [7:0] d);
      tick = t; wr_en = we; wr_sel = sel; wr_data = d;
      @(posedge clk); #1;
      tick = 0; wr_en = 0; wr_sel = 0; wr_data = '0;
      if (rst_req || irq_req) seen = 1'b1;
   endtask

   task automatic ticks(int n);
      for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 1'b0, 8'h00);
   endtask

   task automatic do_reset();
      rst_n = 1'b0; tick = 0; wr_en = 0; wr_sel = 0; wr_data = '0;
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      seen = 1'b0;
   endtask

   task automatic t_reset_count();
      do_reset();
      chk("R1 reset count", count, 0);
      chk("R1 reset requests", {rst_req, irq_req}, 0);
      ticks(3);
      chk("R1 R11 three ticks", count, 3);
      cyc(1'b0, 1'b0, 1'b0, 8'h00);
      cyc(1'b0, 1'b0, 1'b0, 8'h00);
      chk("R1 hold without tick", count, 3);
   endtask

   task automatic t_ovf_reset();
      do_reset();
      ticks(255);
      chk("R11 count at max", count, 8'hFF);
      chk("R2 no request before wrap", seen, 0);
      ticks(1);
      chk("R2 wrap count", count, 0);
      chk("R2 reset request", {rst_req, irq_req}, 2'b10);
      cyc(1'b0, 1'b0, 1'b0, 8'h00);
      chk("R2 reset pulse one cycle", rst_req, 0);
   endtask

   task automatic t_ovf_irq();
      do_reset();
      cyc(1'b0, 1'b1, 1'b0, 8'h01);
      seen = 1'b0;
      ticks(255);
      chk("R2 no irq before wrap", seen, 0);
      ticks(1);
      chk("R2 interrupt request", {rst_req, irq_req}, 2'b01);
      cyc(1'b0, 1'b0, 1'b0, 8'h00);
      chk("R2 irq pulse one cycle", irq_req, 0);
   endtask

   task automatic t_stop_restart();
      do_reset();
      cyc(1'b0, 1'b1, 1'b0, 8'h08);
      ticks(5);
      chk("R3 enable bit alone keeps counting", count, 5);
      cyc(1'b0, 1'b1, 1'b1, 8'hB1);
      chk("R4 stop forces zero", count, 0);
      seen = 1'b0;
      ticks(300);
      chk("R4 stays zero", count, 0);
      chk("R4 no request while stopped", seen, 0);
      cyc(1'b0, 1'b1, 1'b1, 8'h4E);
      chk("R10 clear while stopped ignored", {rst_req, irq_req}, 0);
      cyc(1'b0, 1'b1, 1'b0, 8'h09);
      ticks(4);
      chk("R5 restart counts from zero", count, 4);
   endtask

   task automatic t_clear_any();
      do_reset();
      ticks(200);
      cyc(1'b0, 1'b1, 1'b1, 8'h4E);
      chk("R6 clear at 200", count, 0);
      chk("R6 no request", irq_req, 0);
      ticks(1);
      cyc(1'b1, 1'b1, 1'b1, 8'h4E);
      chk("R6 clear at 1 beats tick", count, 0);
   endtask

   task automatic t_window(int w, int thr);
      do_reset();
      cyc(1'b0, 1'b1, 1'b0, 8'(8 | (w << 1) | 1));
      ticks(thr - 1);
      cyc(1'b0, 1'b1, 1'b1, 8'h4E);
      chk($sformatf("R8 early clear keeps count w=%0d", w), count, thr - 1);
      chk($sformatf("R8 early clear irq w=%0d", w), irq_req, 1);
      ticks(1);
      chk($sformatf("R8 count continues w=%0d", w), count, thr);
      chk($sformatf("R8 irq ended w=%0d", w), irq_req, 0);
      cyc(1'b0, 1'b1, 1'b1, 8'h4E);
      chk($sformatf("R7 clear at threshold w=%0d", w), count, 0);
      chk($sformatf("R7 no request w=%0d", w), irq_req, 0);
   endtask

   task automatic t_stop_vs_ovf();
      do_reset();
      ticks(255);
      cyc(1'b1, 1'b1, 1'b1, 8'hB1);
      chk("R9 en=1 no request", {rst_req, irq_req}, 0);
      chk("R9 en=1 wrapped", count, 0);
      ticks(1);
      chk("R9 en=1 keeps running", count, 1);
      do_reset();
      cyc(1'b0, 1'b1, 1'b0, 8'h08);
      ticks(255);
      cyc(1'b1, 1'b1, 1'b1, 8'hB1);
      chk("R9 en=0 no request", {rst_req, irq_req}, 0);
      ticks(3);
      chk("R9 en=0 stopped", count, 0);
   endtask

   task automatic t_other_codes();
      do_reset();
      ticks(10);
      cyc(1'b0, 1'b1, 1'b1, 8'h00);
      cyc(1'b0, 1'b1, 1'b1, 8'hFF);
      cyc(1'b0, 1'b1, 1'b1, 8'h4F);
      chk("R10 other codes keep count", count, 10);
      chk("R10 other codes no request", seen, 0);
   endtask

   initial begin
      #1_000_000;
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      t_reset_count();
      t_ovf_reset();
      t_ovf_irq();
      t_stop_restart();
      t_clear_any();
      t_window(1, 8'h80);
      t_window(2, 8'hC0);
      t_window(3, 8'hE0);
      t_stop_vs_ovf();
      t_other_codes();
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule